// File: doc/BRIEF.md
# General-Purpose I/O Bank with Atomic Bit Operations

This block is one bank of general-purpose pins, programmed over a simple single-cycle register bus. Each pin has its own direction bit and an output data bit. Software can change any mix of output bits in one bus write without a read-modify-write: separate addresses set, clear or toggle exactly the bits written as one, and a fourth address replaces the whole data word. Pin levels come in through a two-flop synchronizer and an input-enable gate, and can be read back as a status word.

Every pin can feed the single interrupt line. A pin configured as input takes its interrupt source from the synchronized pin level; a pin configured as output takes it from its own data bit, so software raises an interrupt by writing the data register. Each pin is level-sensitive or edge-sensitive, and in edge mode it reacts to rising edges only or to both edges. Edge events are latched in flags that software clears by writing ones. A mask, changed through its own set and clear addresses, selects which pins reach the interrupt output. A per-pin function-select bit hands the pin to another peripheral by dropping the bank's output enable.

Top module: `gpio_bank`

## Requirements
- R1: With function select 0, `pin_oe_o[i]` equals the direction bit written at address 0 (1 = output, 0 = input).
- R2: A write to address 1 replaces the output data word; `pin_o` shows it after the write edge, and reads of addresses 1 to 4 return it.
- R3: A write to address 2 sets the data bits written as one and leaves every other bit unchanged.
- R4: A write to address 3 clears the data bits written as one and leaves every other bit unchanged.
- R5: A write to address 4 inverts the data bits written as one and leaves every other bit unchanged.
- R6: A read of address 5 returns the synchronized pin level ANDed with the input-enable bits written at address 11; a pin change is visible there within three clock cycles.
- R7: After reset, direction, data, input enable, mask, sensitivity, both-edge, flags and function select are all zero, so `pin_oe_o`, `pin_o`, the status read and `irq_o` are zero.
- R8: Writing ones to address 6 enables those pins' interrupts, writing ones to address 7 disables them, other bits keep their state; reads of address 6 or 7 return the mask.
- R9: A pin whose sensitivity bit (address 8) is 0 is level-sensitive: its flag (read at address 10) follows its interrupt source, and `irq_o` is high one cycle after any enabled pin's flag is high.
- R10: A pin whose sensitivity bit is 1 latches its flag on a rising source edge when its both-edge bit (address 9) is 0, and on either edge when it is 1.
- R11: Writing ones to address 10 clears the latched edge flags at those positions; the other flags are unchanged.
- R12: The interrupt source of a pin is its data bit when its direction bit is 1 and its gated pin level when the direction bit is 0.
- R13: A function-select bit of 1 (address 12) forces that pin's `pin_oe_o` to 0 regardless of direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | N | Write data |
| bus_rdata | output | N | Read data for `bus_addr`, combinational |
| pin_i | input | N | Raw pin levels |
| pin_o | output | N | Output data |
| pin_oe_o | output | N | Output enable per pin |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench targets bits that must survive a set, clear or toggle write; a design that decoded these as plain writes would corrupt neighbouring pins. It drives edge-mode pins through falling edges with the both-edge bit clear, where a design that detected any change would flag falsely, and it toggles output pins so that a design ignoring direction in the source selection would miss the software interrupt. It also clears flags while other pins stay flagged, and enables input buffers after a pin is already high, which a design without the input gate would treat as no edge.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        REG_DIR   = 4'd0,
        REG_DATA  = 4'd1,
        REG_SET   = 4'd2,
        REG_CLR   = 4'd3,
        REG_TGL   = 4'd4,
        REG_STAT  = 4'd5,
        REG_MSET  = 4'd6,
        REG_MCLR  = 4'd7,
        REG_EDGE  = 4'd8,
        REG_BOTH  = 4'd9,
        REG_FLAG  = 4'd10,
        REG_INEN  = 4'd11,
        REG_FSEL  = 4'd12
    } reg_addr_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int N      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);
    logic [N-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_i,
    input  logic [N-1:0] edge_sel_i,
    input  logic [N-1:0] both_sel_i,
    input  logic [N-1:0] mask_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o,
    output logic         irq_o
);
    typedef struct packed {
        logic [N-1:0] prev;
        logic [N-1:0] latch;
        logic         irq;
    } irq_state_t;

    irq_state_t st_d, st_q;
    logic [N-1:0] rise_w, fall_w, event_w, eff_w;

    always_comb begin
        rise_w  = src_i & ~st_q.prev;
        fall_w  = ~src_i & st_q.prev;
        event_w = edge_sel_i & (rise_w | (both_sel_i & fall_w));
        eff_w   = (edge_sel_i & st_q.latch) | (~edge_sel_i & src_i);

        st_d       = st_q;
        st_d.prev  = src_i;
        st_d.latch = (st_q.latch & ~clr_i) | event_w;
        st_d.irq   = |(eff_w & mask_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = eff_w;
    assign irq_o   = st_q.irq;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int N = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N-1:0]      bus_wdata,
    output logic [N-1:0]      bus_rdata,
    input  logic [N-1:0]      pin_i,
    output logic [N-1:0]      pin_o,
    output logic [N-1:0]      pin_oe_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [N-1:0] dir;
        logic [N-1:0] data;
        logic [N-1:0] inen;
        logic [N-1:0] mask;
        logic [N-1:0] edge_sel;
        logic [N-1:0] both_sel;
        logic [N-1:0] fsel;
    } regs_t;

    regs_t        r_d, r_q;
    logic [N-1:0] sync_w, level_w, src_w, flags_w, clr_w;

    gpio_sync #(.N(N), .STAGES(2)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (sync_w)
    );

    always_comb begin
        r_d   = r_q;
        clr_w = '0;
        if (bus_we) begin
            unique case (bus_addr)
                REG_DIR:  r_d.dir      = bus_wdata;
                REG_DATA: r_d.data     = bus_wdata;
                REG_SET:  r_d.data     = r_q.data | bus_wdata;
                REG_CLR:  r_d.data     = r_q.data & ~bus_wdata;
                REG_TGL:  r_d.data     = r_q.data ^ bus_wdata;
                REG_MSET: r_d.mask     = r_q.mask | bus_wdata;
                REG_MCLR: r_d.mask     = r_q.mask & ~bus_wdata;
                REG_EDGE: r_d.edge_sel = bus_wdata;
                REG_BOTH: r_d.both_sel = bus_wdata;
                REG_FLAG: clr_w        = bus_wdata;
                REG_INEN: r_d.inen     = bus_wdata;
                REG_FSEL: r_d.fsel     = bus_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign level_w = sync_w & r_q.inen;
    assign src_w   = (r_q.dir & r_q.data) | (~r_q.dir & level_w);

    gpio_irq_unit #(.N(N)) irq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_i      (src_w),
        .edge_sel_i (r_q.edge_sel),
        .both_sel_i (r_q.both_sel),
        .mask_i     (r_q.mask),
        .clr_i      (clr_w),
        .flags_o    (flags_w),
        .irq_o      (irq_o)
    );

    always_comb begin
        unique case (bus_addr)
            REG_DIR:                    bus_rdata = r_q.dir;
            REG_DATA, REG_SET,
            REG_CLR, REG_TGL:           bus_rdata = r_q.data;
            REG_STAT:                   bus_rdata = level_w;
            REG_MSET, REG_MCLR:         bus_rdata = r_q.mask;
            REG_EDGE:                   bus_rdata = r_q.edge_sel;
            REG_BOTH:                   bus_rdata = r_q.both_sel;
            REG_FLAG:                   bus_rdata = flags_w;
            REG_INEN:                   bus_rdata = r_q.inen;
            REG_FSEL:                   bus_rdata = r_q.fsel;
            default:                    bus_rdata = '0;
        endcase
    end

    assign pin_o    = r_q.data;
    assign pin_oe_o = r_q.dir & ~r_q.fsel;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int N = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [N-1:0]      bus_wdata,
    input logic [N-1:0]      pin_o,
    input logic              irq_o
);
    a_r2_direct_write: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_we && bus_addr == REG_DATA) |-> pin_o == $past(bus_wdata));

    a_r3_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_we && bus_addr == REG_SET) |->
            ((pin_o & $past(bus_wdata)) == $past(bus_wdata)) &&
            ((pin_o & ~$past(bus_wdata)) == ($past(pin_o) & ~$past(bus_wdata))));

    a_r4_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_we && bus_addr == REG_CLR) |->
            ((pin_o & $past(bus_wdata)) == '0) &&
            ((pin_o & ~$past(bus_wdata)) == ($past(pin_o) & ~$past(bus_wdata))));

    a_r5_toggle_bits: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_we && bus_addr == REG_TGL) |-> pin_o == ($past(pin_o) ^ $past(bus_wdata)));

    a_r8_mask_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_we && bus_addr == REG_MCLR && (&bus_wdata)) |=> !irq_o);

    a_r1_no_write_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!bus_we) |-> $stable(pin_o));
endmodule

bind gpio_bank gpio_bank_chk #(.N(N)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pin_o     (pin_o),
    .irq_o     (irq_o)
);

// File: tb/gpio_bank_tb_top.sv
module gpio_bank_tb_top;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_we = 1'b0;
    logic [3:0]   bus_addr = '0;
    logic [N-1:0] bus_wdata = '0;
    logic [N-1:0] bus_rdata;
    logic [N-1:0] pin_i = '0;
    logic [N-1:0] pin_o, pin_oe_o;
    logic         irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench model of programmable state
    logic [N-1:0] m_dir = '0, m_data = '0, m_inen = '0, m_mask = '0;
    logic [N-1:0] m_edge = '0, m_both = '0, m_flag = '0, m_fsel = '0;
    logic [N-1:0] m_pin = '0, m_src = '0;

    always #2.5 clk = ~clk;

    gpio_bank #(.N(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_i(pin_i),
        .pin_o(pin_o), .pin_oe_o(pin_oe_o), .irq_o(irq_o)
    );

    function automatic logic [N-1:0] calc_src();
        return (m_dir & m_data) | (~m_dir & m_pin & m_inen);
    endfunction

    function automatic logic [N-1:0] calc_flags();
        return (m_edge & m_flag) | (~m_edge & m_src);
    endfunction

    task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic update_model();
        logic [N-1:0] ns;
        ns = calc_src();
        m_flag = m_flag | (m_edge & ((ns & ~m_src) | (m_both & ~ns & m_src)));
        m_src = ns;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic wr(logic [3:0] a, logic [N-1:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        case (a)
            4'd0:  m_dir  = d;
            4'd1:  m_data = d;
            4'd2:  m_data = m_data | d;
            4'd3:  m_data = m_data & ~d;
            4'd4:  m_data = m_data ^ d;
            4'd6:  m_mask = m_mask | d;
            4'd7:  m_mask = m_mask & ~d;
            4'd8:  m_edge = d;
            4'd9:  m_both = d;
            4'd10: m_flag = m_flag & ~d;
            4'd11: m_inen = d;
            4'd12: m_fsel = d;
            default: ;
        endcase
        update_model();
        settle();
    endtask

    task automatic drive_pins(logic [N-1:0] v);
        @(negedge clk);
        pin_i = v; m_pin = v;
        update_model();
        settle();
    endtask

    task automatic rd(logic [3:0] a, output logic [N-1:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic check_all(string tag);
        logic [N-1:0] v;
        check({tag, " R2 pin_o"}, pin_o, m_data);
        check({tag, " R1/R13 oe"}, pin_oe_o, m_dir & ~m_fsel);
        rd(4'd5, v);  check({tag, " R6 status"}, v, m_pin & m_inen);
        rd(4'd6, v);  check({tag, " R8 mask"}, v, m_mask);
        rd(4'd10, v); check({tag, " R9/R10 flags"}, v, calc_flags());
        check({tag, " R9 irq"}, {{(N-1){1'b0}}, irq_o}, {{(N-1){1'b0}}, |(calc_flags() & m_mask)});
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] v;
        void'($urandom(32'd4711));
        pin_i = 8'hFF; m_pin = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        // R7: reset state, pins high but input buffers off
        check("R7 oe", pin_oe_o, '0);
        check("R7 data", pin_o, '0);
        rd(4'd5, v); check("R7 status", v, '0);
        check("R7 irq", {7'b0, irq_o}, '0);

        // R6, R10: enabling input buffers with pin already high is a rising edge
        wr(4'd8, 8'h01); wr(4'd6, 8'h01); wr(4'd11, 8'hFF);
        check_all("inen");
        // R11: clear the flag, irq drops
        wr(4'd10, 8'h01);
        rd(4'd10, v); check("R11 flag cleared", v & 8'h01, 8'h00);
        // R10: falling with rising-only must not flag
        drive_pins(8'h00);
        rd(4'd10, v); check("R10 fall ignored", v & 8'h01, 8'h00);
        // R10: both-edge catches falls
        wr(4'd9, 8'h01); drive_pins(8'h01); wr(4'd10, 8'h01); drive_pins(8'h00);
        rd(4'd10, v); check("R10 both fall", v & 8'h01, 8'h01);
        // R11: clear one flag, other stays
        wr(4'd8, 8'h03); drive_pins(8'h02); wr(4'd10, 8'h01);
        rd(4'd10, v); check("R11 partial clear", v & 8'h03, 8'h02);
        // R9: level pin follows source
        wr(4'd8, 8'h00); wr(4'd6, 8'h10); drive_pins(8'h10);
        check("R9 level irq", {7'b0, irq_o}, 8'h01);
        drive_pins(8'h00);
        check("R9 level low", {7'b0, irq_o}, 8'h00);
        // R12: output pin software interrupt via toggle
        wr(4'd0, 8'h20); wr(4'd6, 8'h20); wr(4'd4, 8'h20);
        check("R12 sw irq", {7'b0, irq_o}, 8'h01);
        // R13: function select kills oe
        wr(4'd12, 8'h20);
        check("R13 oe", pin_oe_o, 8'h00);
        // R3/R4/R5: keep-other-bits patterns
        wr(4'd1, 8'hA5); wr(4'd2, 8'h0F); check("R3 set", pin_o, 8'hAF);
        wr(4'd3, 8'hF0); check("R4 clr", pin_o, 8'h0F);
        wr(4'd4, 8'h3C); check("R5 tgl", pin_o, 8'h33);
        check_all("directed");

        for (int i = 0; i < 400; i++) begin
            int op;
            op = $urandom_range(0, 13);
            if (op == 13) drive_pins(N'($urandom));
            else if (op == 5) wr(4'd5, N'($urandom));
            else wr(op[3:0], N'($urandom));
            check_all("rand");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule